// File: doc/BRIEF.md
# Command Strobe Decoder with Double-Buffered DAC Code Register

This block sits on a 16-bit register write bus and serves two register addresses. The first is a write-one-to-execute command register. Each set bit turns into a single-cycle strobe for an external handler: software reset, status clear, flash backup, factory calibration restore and autonull. A further bit latches the DAC code. The command bits clear themselves, so the register always reads back as zero.

The second address is the staging half of a 12-bit auxiliary DAC code register. Software writes it one byte lane at a time. The output port that feeds the analog converter changes only when the latch command is issued, so a code that is only half written never reaches the output. Code 0 means 0 V, and each code step is 0.6105 mV. Both halves of the DAC register are volatile. They clear on the hardware reset and on a software reset.

Top module: `cmd_dac_latch`

## Requirements
- R1: After reset all strobe outputs are 0, `dac_code` is 0, and reading the DAC address returns 0.
- R2: A write to the command address with the low byte lane enabled raises one strobe for exactly one cycle, starting one clock after the write edge, for each set bit: bit 7 gives software reset, bit 4 gives status clear, bit 3 gives flash backup, bit 1 gives factory restore and bit 0 gives autonull.
- R3: Command bits written as 0 have no effect. Bits 15:8, 6 and 5 have no effect. The command address always reads back 0.
- R4: Several command bits set in one write give all their strobes in the same cycle. If bit 7 is also set, only the software reset strobe fires, and the DAC latch does not happen.
- R5: A write to the DAC address stores bits 7:0 when `wr_be[0]` is 1 and bits 11:8 when `wr_be[1]` is 1. Bits 15:12 are ignored. Reading the DAC address returns the staged code in bits 11:0 and 0 in bits 15:12.
- R6: `dac_code` keeps its value until command bit 2 is written. It then takes the staged code on the second rising edge after that write.
- R7: A software reset clears both the staged code and `dac_code` to 0 on the second rising edge after the command write.
- R8: A write to any address other than the two served addresses changes no state and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data |
| wr_be | input | 2 | Byte lane enables; bit 0 for data 7:0 |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| dac_code | output | 12 | Latched code driven to the converter |
| sw_reset_o | output | 1 | Software reset strobe |
| status_clear_o | output | 1 | Synchronous clear for the status register |
| flash_save_o | output | 1 | Flash backup strobe |
| cal_restore_o | output | 1 | Factory calibration restore strobe |
| autonull_o | output | 1 | Autonull strobe |

## Verification
The bench builds the block with the default 16-bit bus and 12-bit code. With these values the high byte lane covers only four real bits, so the masking of bits 15:12 can be observed on readback. Split-lane writes show that a half-written code stays off the output until the latch. Command words that combine the software reset with other bits, including the latch bit, show that the reset blocks the other commands and clears both halves of the DAC register.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
   localparam int CB_AUTONULL = 0;
   localparam int CB_RESTORE  = 1;
   localparam int CB_LATCH    = 2;
   localparam int CB_FLASH    = 3;
   localparam int CB_STCLR    = 4;
   localparam int CB_SWRST    = 7;
   localparam int CB_TOP      = 7;

   typedef struct packed {
      logic swrst;
      logic stclr;
      logic flash;
      logic latch;
      logic restore;
      logic autonull;
   } cmd_stb_t;
endpackage

// File: rtl/cdl_cmd_decode.sv
module cdl_cmd_decode
   import cdl_pkg::*;
#(
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [BUS_W-1:0] cmd_data,
   output cmd_stb_t         stb
);
   if (BUS_W <= CB_TOP) begin : g_bad_width
      $error("cdl_cmd_decode: bus too narrow for command bits");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb <= '0;
      end else begin
         stb <= '0;
         if (cmd_we) begin
            if (cmd_data[CB_SWRST]) begin
               stb.swrst <= 1'b1;
            end else begin
               stb.stclr    <= cmd_data[CB_STCLR];
               stb.flash    <= cmd_data[CB_FLASH];
               stb.latch    <= cmd_data[CB_LATCH];
               stb.restore  <= cmd_data[CB_RESTORE];
               stb.autonull <= cmd_data[CB_AUTONULL];
            end
         end
      end
   end

   // R2: a strobe only ever follows a command write
   a_r2_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      (stb != '0) |-> $past(cmd_we));
   // R4: software reset suppresses every other strobe
   a_r4_swrst_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      stb.swrst |-> (stb.stclr == 1'b0 && stb.flash == 1'b0 && stb.latch == 1'b0 &&
                     stb.restore == 1'b0 && stb.autonull == 1'b0));
endmodule

// File: rtl/cdl_dac_reg.sv
module cdl_dac_reg #(
   parameter int BUS_W = 16,
   parameter int DAC_W = 12,
   localparam int NB   = BUS_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [NB-1:0]    be,
   input  logic [BUS_W-1:0] wdata,
   input  logic             latch,
   input  logic             clr,
   output logic [DAC_W-1:0] staged,
   output logic [DAC_W-1:0] dac_out
);
   if (DAC_W < 1 || DAC_W > BUS_W) begin : g_bad_width
      $error("cdl_dac_reg: code width must fit the bus");
   end

   for (genvar b = 0; b < NB; b++) begin : g_lane
      localparam int LO = b * 8;
      localparam int HI = ((LO + 8) < DAC_W) ? (LO + 7) : (DAC_W - 1);
      if (LO < DAC_W) begin : g_used
         logic [HI-LO:0] lane_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               lane_q <= '0;
            end else if (we && be[b]) begin
               lane_q <= wdata[HI:LO];
            end
         end
         assign staged[HI:LO] = lane_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         dac_out <= '0;
      end else if (latch) begin
         dac_out <= staged;
      end
   end

   // R6: output holds without a latch
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch && !clr) |=> $stable(dac_out));
   // R6: latch copies the staged code
   a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && !clr) |=> (dac_out == $past(staged)));
   // R7: clear empties both halves
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (dac_out == '0 && staged == '0));
endmodule

// File: rtl/cmd_dac_latch.sv
module cmd_dac_latch
   import cdl_pkg::*;
#(
   parameter int          BUS_W    = 16,
   parameter int          DAC_W    = 12,
   parameter int          ADDR_W   = 6,
   parameter logic [5:0]  CMD_ADDR = 6'h3E,
   parameter logic [5:0]  DAC_ADDR = 6'h30,
   localparam int         NB       = BUS_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic [NB-1:0]     wr_be,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BUS_W-1:0]  rd_data,
   output logic [DAC_W-1:0]  dac_code,
   output logic              sw_reset_o,
   output logic              status_clear_o,
   output logic              flash_save_o,
   output logic              cal_restore_o,
   output logic              autonull_o
);
   if (BUS_W % 8 != 0 || BUS_W < 8) begin : g_bad_bus
      $error("cmd_dac_latch: bus width must be whole bytes");
   end
   if (CMD_ADDR == DAC_ADDR) begin : g_bad_addr
      $error("cmd_dac_latch: register addresses must differ");
   end
   if (ADDR_W > 6 || ADDR_W < 1) begin : g_bad_aw
      $error("cmd_dac_latch: address width out of range");
   end

   localparam logic [ADDR_W-1:0] CMD_A = CMD_ADDR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] DAC_A = DAC_ADDR[ADDR_W-1:0];

   cmd_stb_t         stb;
   logic [DAC_W-1:0] staged;
   logic             cmd_we, dac_we;

   assign cmd_we = wr_en && (wr_addr == CMD_A) && wr_be[0];
   assign dac_we = wr_en && (wr_addr == DAC_A);

   cdl_cmd_decode #(.BUS_W(BUS_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(wr_data), .stb(stb)
   );

   cdl_dac_reg #(.BUS_W(BUS_W), .DAC_W(DAC_W)) u_dac (
      .clk(clk), .rst_n(rst_n), .we(dac_we), .be(wr_be), .wdata(wr_data),
      .latch(stb.latch), .clr(stb.swrst), .staged(staged), .dac_out(dac_code)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == DAC_A) rd_data[DAC_W-1:0] = staged;
   end

   assign sw_reset_o     = stb.swrst;
   assign status_clear_o = stb.stclr;
   assign flash_save_o   = stb.flash;
   assign cal_restore_o  = stb.restore;
   assign autonull_o     = stb.autonull;

   // R8: a write elsewhere leaves the staged code alone
   a_r8_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != DAC_A && wr_addr != CMD_A && !stb.swrst) |=> $stable(staged));
   // R1: reset leaves the output at zero
   a_r1_reset_zero: assert property (@(posedge clk) !rst_n |=> (dac_code == '0));
endmodule

// File: tb/cmd_dac_latch_test.sv
module cmd_dac_latch_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  wr_be = '0;
   logic [5:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic [11:0] dac_code;
   logic        sw_reset_o, status_clear_o, flash_save_o, cal_restore_o, autonull_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit mon_on  = 1'b0;
   bit done    = 1'b0;
   logic [4:0] exp_q[$];

   localparam logic [5:0] A_CMD = 6'h3E;
   localparam logic [5:0] A_DAC = 6'h30;

   always #5 clk = ~clk;

   cmd_dac_latch #(.BUS_W(16), .DAC_W(12)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data), .dac_code(dac_code),
      .sw_reset_o(sw_reset_o), .status_clear_o(status_clear_o), .flash_save_o(flash_save_o),
      .cal_restore_o(cal_restore_o), .autonull_o(autonull_o)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic [1:0] be);
      if (a == A_CMD && be[0]) begin
         logic [4:0] e;
         e = d[7] ? 5'b10000 : {1'b0, d[4], d[3], d[1], d[0]};
         if (e != 5'b0) exp_q.push_back(e);
      end
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; wr_be = '0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   // monitor: pops one expected strobe set per observed strobe cycle
   always @(negedge clk) begin
      if (mon_on) begin
         logic [4:0] v;
         v = {sw_reset_o, status_clear_o, flash_save_o, cal_restore_o, autonull_o};
         if (v != 5'b0) begin
            if (exp_q.size() == 0) check("R2/R3 unexpected strobe", {11'b0, v}, 16'h0);
            else check("R2/R4 strobe set", {11'b0, v}, {11'b0, exp_q.pop_front()});
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 dac_code", {4'b0, dac_code}, 16'h0);
      rd(A_DAC, v); check("R1 readback", v, 16'h0);
      check("R1 strobes", {11'b0, sw_reset_o, status_clear_o, flash_save_o,
                           cal_restore_o, autonull_o}, 16'h0);
      // R2 single bits
      wr(A_CMD, 16'h0010, 2'b01);
      wr(A_CMD, 16'h0008, 2'b01);
      wr(A_CMD, 16'h0002, 2'b01);
      wr(A_CMD, 16'h0001, 2'b01);
      // R3 zero and unused bits
      wr(A_CMD, 16'h0000, 2'b11);
      wr(A_CMD, 16'hFF60, 2'b11);
      rd(A_CMD, v); check("R3 command readback", v, 16'h0);
      // R4 combined
      wr(A_CMD, 16'h001B, 2'b01);
      // R5/R6 staged byte writes
      wr(A_DAC, 16'h12AB, 2'b01);
      rd(A_DAC, v); check("R5 low lane", v, 16'h00AB);
      check("R6 held after low lane", {4'b0, dac_code}, 16'h0);
      wr(A_DAC, 16'hFC77, 2'b10);
      rd(A_DAC, v); check("R5 high lane masked", v, 16'h0CAB);
      check("R6 held after high lane", {4'b0, dac_code}, 16'h0);
      wr(A_CMD, 16'h0004, 2'b01);
      @(negedge clk);
      check("R6 latched", {4'b0, dac_code}, 16'h0CAB);
      wr(A_DAC, 16'h0123, 2'b11);
      @(negedge clk);
      check("R6 held after full write", {4'b0, dac_code}, 16'h0CAB);
      wr(A_CMD, 16'h0006, 2'b01);
      @(negedge clk);
      check("R6 latched second", {4'b0, dac_code}, 16'h0123);
      // R8 other address
      wr(6'h11, 16'hFFFF, 2'b11);
      @(negedge clk);
      rd(A_DAC, v); check("R8 staged untouched", v, 16'h0123);
      check("R8 output untouched", {4'b0, dac_code}, 16'h0123);
      // R4/R7 software reset blocks latch and clears
      wr(A_DAC, 16'h0456, 2'b11);
      wr(A_CMD, 16'h009F, 2'b01);
      @(negedge clk);
      check("R7 output cleared", {4'b0, dac_code}, 16'h0);
      rd(A_DAC, v); check("R7 staged cleared", v, 16'h0);
      wr(A_CMD, 16'h0004, 2'b01);
      @(negedge clk);
      check("R7 latch after reset", {4'b0, dac_code}, 16'h0);
      repeat (3) @(negedge clk);
      check("R2 all expected strobes seen", exp_q.size(), 16'h0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule